// File: doc/BRIEF.md
# Routed Level-Sensitive Interrupt Aggregator

This block gathers a set of level-sensitive interrupt lines, grouped into words of 32, and presents them to several upstream interrupt controllers. Software sees each word as a small register group holding a mask of enabled lines, a read-only view of the raw line levels, and a mask of lines that may raise a wake request. Nothing is ever acknowledged here: a line stays pending for as long as its source holds it high.

Each upstream output has its own fixed routing mask per word, chosen at build time, so different controllers can take different subsets of the same lines. An output whose routing is left unconfigured passes every enabled line. Enables come out of reset preloaded with a build-time forwarding pattern. When the low-power input is high, lines in the wake mask count as enabled too, and a separate wake output reports any active line that is wake-enabled. When low power is left, only the normal enable register applies again.

Top module: `l2_irq_router`

## Requirements
- R1: During and after reset the parent outputs and the wake output are 0, each word's enable register holds its slice of `FWD_INIT` (word w in bits w*32+31..w*32), and each wake-enable register holds 0.
- R2: Word w's registers sit at byte address 16*w plus an offset: 0x0 enable, 0x4 status, 0x8 wake-enable; a read strobe places the selected value on `rdata` at the next clock edge, and `rdata` holds it until the next read.
- R3: A write to an enable register replaces the whole word; a 1 bit lets that line through, a 0 bit blocks it, from the first clock edge after the write.
- R4: The status word equals the source lines one clock later; there is no acknowledge, writes to status change nothing, and a status bit returns to 0 only when its source drops.
- R5: Parent output p is a register that goes high two clock edges after any line becomes active with status, effective enable and p's routing bit all 1, and goes low two edges after no such line remains.
- R6: Routing masks are packed parent-major, word-minor (parent p, word w at slice index p*NUM_WORDS+w of `ROUTE_MASK`); a parent whose `HAS_ROUTE` bit is 0 uses an all-ones mask regardless of `ROUTE_MASK`.
- R7: While `lowpwr` is 1 the effective enable of each word is enable OR wake-enable; on `lowpwr` falling only the enable register applies again, and the enable register is never altered by low-power entry or exit; parent outputs follow `lowpwr` one edge later.
- R8: `wake_irq` is a register that is 1 exactly when, at the previous edge, `lowpwr` was 1 and some status bit and its wake-enable bit were both 1.
- R9: Reads of a word index at or above `NUM_WORDS`, of offset 0xC, of an address with nonzero bits 1..0 or bits above 5 return 0, and writes to such addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_irq | input | NUM_WORDS*WORD_W | Level-sensitive source lines, word w in slice w |
| lowpwr | input | 1 | Low-power mode, wake-enables join the enables |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | WORD_W | Write data |
| rdata | output | WORD_W | Registered read data |
| parent_irq | output | NUM_PARENTS | Registered upstream interrupt outputs |
| wake_irq | output | 1 | Registered wake request |

## Verification
A source change reaches status one edge later and the parent outputs two edges later; an enable write and a `lowpwr` change reach the parent outputs one edge after the write or level is applied, and `wake_irq` follows `lowpwr` by one edge. Read data is due on the edge that samples the strobe. Stimulus is applied at falling edges and every directed check waits exactly that many falling edges before sampling, and a behavioural model with the same latencies is compared against all three outputs at every falling edge after reset.

// File: rtl/l2ir_pkg.sv
package l2ir_pkg;
  localparam int REG_LSB  = 2;
  localparam int WORD_LSB = 4;
  localparam int WSEL_W   = 2;

  typedef enum logic [1:0] {
    REG_EN   = 2'd0,
    REG_STAT = 2'd1,
    REG_WAKE = 2'd2,
    REG_RSVD = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/l2ir_regfile.sv
module l2ir_regfile
  import l2ir_pkg::*;
#(
  parameter int NW = 3,
  parameter int WW = 32,
  parameter int AW = 8,
  parameter logic [NW*WW-1:0] FWD_INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [WW-1:0]    wdata,
  input  logic [NW*WW-1:0] src_irq,
  output logic [NW*WW-1:0] en_flat,
  output logic [NW*WW-1:0] wake_flat,
  output logic [NW*WW-1:0] stat_flat,
  output logic [WW-1:0]    rdata
);
  localparam int HI_LSB = WORD_LSB + WSEL_W;

  logic [WSEL_W-1:0] word_sel;
  reg_sel_e          reg_sel;
  logic              hdr_ok;
  logic [NW-1:0]     hit;
  logic [WW-1:0]     rd_val;

  assign word_sel = addr[WORD_LSB +: WSEL_W];
  assign reg_sel  = reg_sel_e'(addr[REG_LSB +: 2]);
  assign hdr_ok   = (addr[REG_LSB-1:0] == '0) && (addr[AW-1:HI_LSB] == '0)
                    && (reg_sel != REG_RSVD);

  for (genvar w = 0; w < NW; w++) begin : g_word
    logic [WW-1:0] en_q;
    logic [WW-1:0] wake_q;
    logic [WW-1:0] stat_q;

    assign hit[w] = hdr_ok && (word_sel == WSEL_W'(w));

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q   <= FWD_INIT[w*WW +: WW];
        wake_q <= '0;
      end else if (wr_en && hit[w]) begin
        if (reg_sel == REG_EN)   en_q   <= wdata;
        if (reg_sel == REG_WAKE) wake_q <= wdata;
      end
    end

    always_ff @(posedge clk) begin
      stat_q <= src_irq[w*WW +: WW];
    end

    assign en_flat[w*WW +: WW]   = en_q;
    assign wake_flat[w*WW +: WW] = wake_q;
    assign stat_flat[w*WW +: WW] = stat_q;
  end

  always_comb begin
    rd_val = '0;
    for (int w = 0; w < NW; w++) begin
      if (hit[w]) begin
        case (reg_sel)
          REG_EN:   rd_val = en_flat[w*WW +: WW];
          REG_STAT: rd_val = stat_flat[w*WW +: WW];
          REG_WAKE: rd_val = wake_flat[w*WW +: WW];
          default:  rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end
endmodule

// File: rtl/l2ir_route.sv
module l2ir_route #(
  parameter int NW = 3,
  parameter int WW = 32,
  parameter int NP = 3,
  parameter logic [NP*NW*WW-1:0] ROUTE_MASK = '1,
  parameter logic [NP-1:0]       HAS_ROUTE  = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NW*WW-1:0] stat_flat,
  input  logic [NW*WW-1:0] eff_en,
  output logic [NP-1:0]    parent_q
);
  for (genvar p = 0; p < NP; p++) begin : g_par
    logic [NW-1:0] word_hit;
    for (genvar w = 0; w < NW; w++) begin : g_w
      logic [WW-1:0] live;
      assign live = stat_flat[w*WW +: WW] & eff_en[w*WW +: WW];
      if (HAS_ROUTE[p]) begin : g_masked
        assign word_hit[w] = |(live & ROUTE_MASK[(p*NW+w)*WW +: WW]);
      end else begin : g_open
        assign word_hit[w] = |live;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) parent_q[p] <= 1'b0;
      else     parent_q[p] <= |word_hit;
    end
  end
endmodule

// File: rtl/l2ir_wake.sv
module l2ir_wake #(
  parameter int NW = 3,
  parameter int WW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lowpwr,
  input  logic [NW*WW-1:0] stat_flat,
  input  logic [NW*WW-1:0] wake_flat,
  output logic             wake_q
);
  always_ff @(posedge clk) begin
    if (rst) wake_q <= 1'b0;
    else     wake_q <= lowpwr && (|(stat_flat & wake_flat));
  end
endmodule

// File: rtl/l2_irq_router.sv
module l2_irq_router #(
  parameter int NUM_WORDS   = 3,
  parameter int WORD_W      = 32,
  parameter int NUM_PARENTS = 3,
  parameter int ADDR_W      = 8,
  parameter logic [NUM_WORDS*WORD_W-1:0] FWD_INIT =
    {32'h0000_00F0, 32'hFFFF_0000, 32'h0000_00FF},
  parameter logic [NUM_PARENTS*NUM_WORDS*WORD_W-1:0] ROUTE_MASK =
    {32'h0000_0000, 32'h0000_0000, 32'h0000_0000,
     32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_0000,
     32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_FFFF},
  parameter logic [NUM_PARENTS-1:0] HAS_ROUTE = 3'b011
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_WORDS*WORD_W-1:0] src_irq,
  input  logic                        lowpwr,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [WORD_W-1:0]           wdata,
  output logic [WORD_W-1:0]           rdata,
  output logic [NUM_PARENTS-1:0]      parent_irq,
  output logic                        wake_irq
);
  localparam int SRC_W = NUM_WORDS * WORD_W;

  logic [SRC_W-1:0] en_flat;
  logic [SRC_W-1:0] wake_flat;
  logic [SRC_W-1:0] stat_flat;
  logic [SRC_W-1:0] eff_en;

  l2ir_regfile #(
    .NW(NUM_WORDS), .WW(WORD_W), .AW(ADDR_W), .FWD_INIT(FWD_INIT)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .src_irq(src_irq), .en_flat(en_flat),
    .wake_flat(wake_flat), .stat_flat(stat_flat), .rdata(rdata)
  );

  assign eff_en = lowpwr ? (en_flat | wake_flat) : en_flat;

  l2ir_route #(
    .NW(NUM_WORDS), .WW(WORD_W), .NP(NUM_PARENTS),
    .ROUTE_MASK(ROUTE_MASK), .HAS_ROUTE(HAS_ROUTE)
  ) u_route (
    .clk(clk), .rst(rst), .stat_flat(stat_flat), .eff_en(eff_en),
    .parent_q(parent_irq)
  );

  l2ir_wake #(.NW(NUM_WORDS), .WW(WORD_W)) u_wake (
    .clk(clk), .rst(rst), .lowpwr(lowpwr), .stat_flat(stat_flat),
    .wake_flat(wake_flat), .wake_q(wake_irq)
  );
endmodule

// File: rtl/l2ir_checker.sv
module l2ir_checker #(
  parameter int NUM_WORDS   = 3,
  parameter int WORD_W      = 32,
  parameter int NUM_PARENTS = 3,
  parameter int ADDR_W      = 8
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NUM_WORDS*WORD_W-1:0] src_irq,
  input logic                        lowpwr,
  input logic                        wr_en,
  input logic [ADDR_W-1:0]           addr,
  input logic [WORD_W-1:0]           wdata,
  input logic [NUM_PARENTS-1:0]      parent_irq,
  input logic                        wake_irq,
  input logic [NUM_WORDS*WORD_W-1:0] stat_flat,
  input logic [NUM_WORDS*WORD_W-1:0] en_flat
);
  logic rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) begin
      p_reset_quiet_r1: assert (parent_irq == '0 && !wake_irq)
        else $error("outputs not quiet after reset edge");
    end
  end

  p_status_track_r4: assert property (@(posedge clk) disable iff (rst)
    stat_flat == $past(src_irq))
    else $error("status does not follow sources");

  p_quiet_src_r5: assert property (@(posedge clk) disable iff (rst)
    (src_irq == '0) |=> ##1 (parent_irq == '0))
    else $error("parent high with no source");

  p_wake_lp_r8: assert property (@(posedge clk) disable iff (rst)
    wake_irq |-> $past(lowpwr))
    else $error("wake raised outside low power");

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_wchk
    p_enable_write_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == ADDR_W'(w*16)) |=> (en_flat[w*WORD_W +: WORD_W] == $past(wdata)))
      else $error("enable write lost");
  end
endmodule

bind l2_irq_router l2ir_checker #(
  .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W),
  .NUM_PARENTS(NUM_PARENTS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .src_irq(src_irq), .lowpwr(lowpwr),
  .wr_en(wr_en), .addr(addr), .wdata(wdata), .parent_irq(parent_irq),
  .wake_irq(wake_irq), .stat_flat(stat_flat), .en_flat(en_flat)
);

// File: tb/l2_irq_router_test.sv
module l2_irq_router_test;
  localparam int NW = 3;
  localparam int WW = 32;
  localparam int NP = 3;
  localparam int AW = 8;
  localparam logic [NW*WW-1:0] FWD = {32'h0000_00F0, 32'hFFFF_0000, 32'h0000_00FF};
  localparam logic [NP*NW*WW-1:0] RM =
    {32'h0000_0000, 32'h0000_0000, 32'h0000_0000,
     32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_0000,
     32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_FFFF};
  localparam logic [NP-1:0] HR = 3'b011;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NW*WW-1:0] src = '0;
  logic lowpwr = 1'b0;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [WW-1:0] wdata = '0;
  logic [WW-1:0] rdata;
  logic [NP-1:0] parent_irq;
  logic wake_irq;

  int checks = 0;
  int failures = 0;
  bit timed_out = 0;

  always #10 clk = ~clk;

  l2_irq_router #(
    .NUM_WORDS(NW), .WORD_W(WW), .NUM_PARENTS(NP), .ADDR_W(AW),
    .FWD_INIT(FWD), .ROUTE_MASK(RM), .HAS_ROUTE(HR)
  ) uut (
    .clk(clk), .rst(rst), .src_irq(src), .lowpwr(lowpwr), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .parent_irq(parent_irq), .wake_irq(wake_irq)
  );

  task automatic check(input string tag, input logic [WW-1:0] got, input logic [WW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [WW-1:0] m_en [NW];
  logic [WW-1:0] m_wk [NW];
  logic [WW-1:0] m_st [NW];
  logic [NP-1:0] m_par;
  logic          m_wake;
  logic [WW-1:0] m_rd;
  logic [NP-1:0] t_par;
  logic          t_wake;
  logic [WW-1:0] t_rd;
  logic [WW-1:0] t_route;
  logic [WW-1:0] t_eff;
  int            t_w;

  always @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < NW; w++) begin
        m_en[w] <= FWD[w*WW +: WW];
        m_wk[w] <= '0;
      end
      m_par  <= '0;
      m_wake <= 1'b0;
      m_rd   <= '0;
    end else begin
      t_par  = '0;
      t_wake = 1'b0;
      for (int p = 0; p < NP; p++) begin
        for (int w = 0; w < NW; w++) begin
          t_route = HR[p] ? RM[(p*NW+w)*WW +: WW] : {WW{1'b1}};
          t_eff   = lowpwr ? (m_en[w] | m_wk[w]) : m_en[w];
          if ((m_st[w] & t_eff & t_route) != 0) t_par[p] = 1'b1;
        end
      end
      for (int w = 0; w < NW; w++)
        if (lowpwr && ((m_st[w] & m_wk[w]) != 0)) t_wake = 1'b1;
      t_rd = m_rd;
      if (rd_en) begin
        t_w  = int'(addr[5:4]);
        t_rd = '0;
        if (addr[1:0] == 0 && addr[7:6] == 0 && t_w < NW) begin
          if (addr[3:2] == 2'd0) t_rd = m_en[t_w];
          if (addr[3:2] == 2'd1) t_rd = m_st[t_w];
          if (addr[3:2] == 2'd2) t_rd = m_wk[t_w];
        end
      end
      if (wr_en && addr[1:0] == 0 && addr[7:6] == 0 && int'(addr[5:4]) < NW) begin
        if (addr[3:2] == 2'd0) m_en[addr[5:4]] <= wdata;
        if (addr[3:2] == 2'd2) m_wk[addr[5:4]] <= wdata;
      end
      m_par  <= t_par;
      m_wake <= t_wake;
      m_rd   <= t_rd;
    end
    for (int w = 0; w < NW; w++) m_st[w] <= src[w*WW +: WW];
  end

  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      check("R5 model parent", WW'(parent_irq), WW'(m_par));
      check("R8 model wake", WW'(wake_irq), WW'(m_wake));
      check("R2 model rdata", rdata, m_rd);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [WW-1:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [WW-1:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic run();
    logic [WW-1:0] v;
    tick(3);
    rst = 1'b0;
    cmp_on = 1;
    check("R1 parent after reset", WW'(parent_irq), '0);
    check("R1 wake after reset", WW'(wake_irq), '0);
    rd(8'h00, v); check("R1 enable w0 preload", v, 32'h0000_00FF);
    rd(8'h10, v); check("R1 enable w1 preload", v, 32'hFFFF_0000);
    rd(8'h20, v); check("R1 enable w2 preload", v, 32'h0000_00F0);
    rd(8'h08, v); check("R1 wake w0 zero", v, 32'h0);

    src[0] = 1'b1;
    tick(1); check("R5 latency not yet", WW'(parent_irq), '0);
    tick(1); check("R5 parent p0,p2", WW'(parent_irq), 32'h5);
    rd(8'h04, v); check("R4 status w0", v, 32'h1);
    wr(8'h04, 32'h0);
    rd(8'h04, v); check("R4 status write ignored", v, 32'h1);
    src[0] = 1'b0;
    tick(2); check("R4 level clears parent", WW'(parent_irq), '0);
    rd(8'h04, v); check("R4 status follows drop", v, 32'h0);

    wr(8'h00, 32'h0001_0000);
    src[16] = 1'b1;
    tick(2); check("R6 upper half routes p1,p2", WW'(parent_irq), 32'h6);
    wr(8'h00, 32'h0);
    tick(1); check("R3 mask by writing 0", WW'(parent_irq), '0);
    src = '0;
    src[40] = 1'b1;
    tick(2); check("R3 disabled line blocked", WW'(parent_irq), '0);
    src[48] = 1'b1;
    tick(2); check("R6 word1 route p0 empty", WW'(parent_irq), 32'h6);
    src = '0;
    src[68] = 1'b1;
    tick(2); check("R6 word2 p1 masked p2 open", WW'(parent_irq), 32'h5);

    src = '0;
    src[64] = 1'b1;
    wr(8'h28, 32'h1);
    tick(2);
    check("R7 no lowpwr no effect", WW'(parent_irq), '0);
    check("R8 no wake outside lowpwr", WW'(wake_irq), '0);
    lowpwr = 1'b1;
    tick(1);
    check("R7 wake mask joins enable", WW'(parent_irq), 32'h5);
    check("R8 wake asserted", WW'(wake_irq), 32'h1);
    rd(8'h20, v); check("R7 enable unchanged in lowpwr", v, 32'h0000_00F0);
    lowpwr = 1'b0;
    tick(1);
    check("R7 exit restores enable", WW'(parent_irq), '0);
    check("R8 wake drops on exit", WW'(wake_irq), '0);
    src = '0;

    wr(8'h00, 32'h0000_0055);
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h30, v); check("R9 missing word reads 0", v, 32'h0);
    wr(8'h0C, 32'h1234_5678);
    rd(8'h0C, v); check("R9 offset 0xC reads 0", v, 32'h0);
    wr(8'h40, 32'hDEAD_BEEF);
    wr(8'h02, 32'hFFFF_FFFF);
    rd(8'h40, v); check("R9 high address reads 0", v, 32'h0);
    rd(8'h00, v); check("R9 stray writes ignored", v, 32'h0000_0055);
    rd(8'h08, v); check("R9 wake w0 untouched", v, 32'h0);
    tick(3);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule